// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This engine carries out one long host-memory transfer that is scattered over many separate memory segments. Software lays out a chain of descriptors in host memory. Each descriptor names one segment by its byte count, its host physical address and its local-side address, and it links to the next descriptor. Software writes the address of the first descriptor and sets a start bit. From then on the engine runs without software help. It fetches each descriptor word by word over a simple read channel. It cuts the segment into pieces that the bus allows and hands them one at a time to a separate data mover. When the descriptor flagged as final is complete, the engine raises an interrupt.

The engine keeps a count of the bytes it has moved during the run. Before it starts any segment, it checks whether that segment would push the run past the programmed byte budget, which defaults to 16 MiB. If it would, the engine stops in an error state and issues none of that segment. A segment with a byte count of zero is passed over without any command. A status code shows at any time whether the engine is idle, fetching, transferring, done or stopped on an error.

Top module: `sgw_walker`

## Requirements
- R1: After reset the status code reads 0 (idle), the moved-byte count reads 0, and `irq`, `dsc_req` and `cmd_valid` are all low.
- R2: Descriptor fetching starts at the programmed list address, and every descriptor word address has bits 1:0 equal to 0. A descriptor is four 32-bit words, in this order: byte count at +0, host address at +4, local address at +8, link at +12. The next descriptor lives at the link word with bits 1:0 cleared, and link bit 0 set marks the final descriptor.
- R3: Every piece issued on the command channel has a length from 1 to 256 bytes.
- R4: No piece crosses a 4096-byte host-address boundary. The pieces of a segment cover it in order and without gaps. Host and local addresses advance by the same amount, and both wrap modulo 2^32.
- R5: After the final descriptor completes, the status code reads 3 (done) and `irq` is high. `irq` stays high until the next start, and a start clears it.
- R6: If the bytes already moved plus the byte count of the next segment would exceed the byte budget, the status code reads 4 (error), `irq` stays low, and no piece of that segment is issued. A run that lands exactly on the budget ends done.
- R7: A descriptor with a byte count of zero issues no command, and the walk carries on along its link or finishes if that descriptor is final.
- R8: Register 3 reads the total of bytes in pieces completed since the last start.
- R9: The register map is as follows. Address 0 holds the list address (written and read back). A write to address 1 with bit 0 set starts a run. Address 2 reads the status code in bits 2:0: 0 idle, 1 fetching, 2 transferring, 3 done, 4 error. Address 3 reads the byte count.
- R10: A start written while the engine is fetching or transferring is ignored. The pieces, the final status and the byte count come out the same as without that write.
- R11: At most one piece is outstanding. The next command is offered only after `cmd_done` for the previous one. A command's fields stay stable while `cmd_valid` waits for `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Byte address of the descriptor word being read |
| dsc_ack | input | 1 | Read accepted; `dsc_rdata` is valid in this cycle |
| dsc_rdata | input | 32 | Descriptor word read data |
| cmd_valid | output | 1 | A piece command is offered |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_host_addr | output | 32 | Host address of the piece |
| cmd_local_addr | output | 32 | Local address of the piece |
| cmd_len | output | 9 | Piece length in bytes (1 to 256) |
| cmd_done | input | 1 | One-cycle pulse: the outstanding piece has finished |
| irq | output | 1 | Completion interrupt, held high while done |

## Verification
Single segments that start just below a 4 KiB host boundary, or near the top of the 32-bit address space, tell apart a correct boundary split and wrap from a plain 256-byte chop. Multi-descriptor chains that are linked out of order through memory, with zero-count entries in the middle and at the end, show whether the link is followed and empty segments are skipped. Two chains, one that lands exactly on the byte budget and one that overshoots it by a segment, separate the inclusive limit from an off-by-one. Random chains of up to four descriptors, with random addresses and counts and random handshake delays on both channels, check the full piece sequence against a model of the walk. A start written mid-transfer shows that a busy engine does not restart.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_CHECK = 3'd2,
        S_ISSUE = 3'd3,
        S_WAIT  = 3'd4,
        S_DONE  = 3'd5,
        S_ERR   = 3'd6
    } sgw_state_e;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_CTRL  = 2'd1;
    localparam logic [1:0] REG_STAT  = 2'd2;
    localparam logic [1:0] REG_BYTES = 2'd3;

    localparam logic [2:0] ST_IDLE  = 3'd0;
    localparam logic [2:0] ST_FETCH = 3'd1;
    localparam logic [2:0] ST_XFER  = 3'd2;
    localparam logic [2:0] ST_DONE  = 3'd3;
    localparam logic [2:0] ST_ERROR = 3'd4;

    // Software-visible code for each internal state.
    function automatic logic [2:0] status_code(sgw_state_e s);
        case (s)
            S_FETCH, S_CHECK: return ST_FETCH;
            S_ISSUE, S_WAIT:  return ST_XFER;
            S_DONE:           return ST_DONE;
            S_ERR:            return ST_ERROR;
            default:          return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sgw_piece.sv
// Size of the next piece: the smallest of the bytes left in the segment,
// the largest piece allowed, and the room before the next host boundary.
module sgw_piece #(
    parameter int DW        = 32,
    parameter int MAX_PIECE = 256,
    parameter int BOUNDARY  = 4096,
    localparam int LEN_W    = $clog2(MAX_PIECE) + 1,
    localparam int BW       = $clog2(BOUNDARY)
) (
    input  logic [DW-1:0]    remain,
    input  logic [BW-1:0]    host_lo,
    output logic [LEN_W-1:0] len
);
    logic [DW-1:0] room_w;
    logic [DW-1:0] cap_w;

    always_comb begin
        room_w = DW'(BOUNDARY) - DW'(host_lo);
        cap_w  = DW'(MAX_PIECE);
        if (room_w < cap_w) cap_w = room_w;
        len = (remain < cap_w) ? remain[LEN_W-1:0] : cap_w[LEN_W-1:0];
    end
endmodule

// File: rtl/sgw_budget.sv
// Flags a segment that would carry the run total past the byte budget.
module sgw_budget #(
    parameter int          DW              = 32,
    parameter int unsigned MAX_TOTAL_BYTES = 32'd16777216
) (
    input  logic [DW-1:0] total,
    input  logic [DW-1:0] add,
    output logic          over
);
    logic [DW:0] sum;

    always_comb begin
        sum  = {1'b0, total} + {1'b0, add};
        over = sum > (DW+1)'(MAX_TOTAL_BYTES);
    end
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
#(
    parameter int          DW              = 32,
    parameter int          MAX_PIECE       = 256,
    parameter int          BOUNDARY        = 4096,
    parameter int unsigned MAX_TOTAL_BYTES = 32'd16777216,
    localparam int         LEN_W           = $clog2(MAX_PIECE) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             dsc_req,
    output logic [DW-1:0]    dsc_addr,
    input  logic             dsc_ack,
    input  logic [DW-1:0]    dsc_rdata,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [DW-1:0]    cmd_host_addr,
    output logic [DW-1:0]    cmd_local_addr,
    output logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_done,
    output logic             irq
);
    localparam int BW = $clog2(BOUNDARY);

    typedef struct packed {
        sgw_state_e    st;
        logic [DW-1:0] base;
        logic [DW-1:0] ptr;
        logic [1:0]    idx;
        logic [DW-1:0] remain;
        logic [DW-1:0] host;
        logic [DW-1:0] loc;
        logic [DW-1:0] next_ptr;
        logic          last;
        logic [DW-1:0] total;
    } ctx_t;

    ctx_t state_d, state_q;

    logic [LEN_W-1:0] piece_len;
    logic [DW-1:0]    piece_w;
    logic             over_budget;
    logic             start;
    logic [DW-1:0]    bytes_moved;

    sgw_piece #(
        .DW(DW), .MAX_PIECE(MAX_PIECE), .BOUNDARY(BOUNDARY)
    ) u_piece (
        .remain (state_q.remain),
        .host_lo(state_q.host[BW-1:0]),
        .len    (piece_len)
    );

    sgw_budget #(
        .DW(DW), .MAX_TOTAL_BYTES(MAX_TOTAL_BYTES)
    ) u_budget (
        .total(state_q.total),
        .add  (state_q.remain),
        .over (over_budget)
    );

    assign piece_w     = DW'(piece_len);
    assign start       = reg_we && (reg_addr == REG_CTRL) && reg_wdata[0];
    assign bytes_moved = state_q.total;

    always_comb begin
        state_d = state_q;

        if (reg_we && reg_addr == REG_BASE) state_d.base = reg_wdata;

        case (state_q.st)
            S_IDLE, S_DONE, S_ERR: begin
                if (start) begin
                    state_d.st    = S_FETCH;
                    state_d.ptr   = state_q.base;
                    state_d.idx   = 2'd0;
                    state_d.total = '0;
                end
            end

            S_FETCH: begin
                if (dsc_ack) begin
                    case (state_q.idx)
                        2'd0: state_d.remain = dsc_rdata;
                        2'd1: state_d.host   = dsc_rdata;
                        2'd2: state_d.loc    = dsc_rdata;
                        default: begin
                            state_d.next_ptr = {dsc_rdata[DW-1:2], 2'b00};
                            state_d.last     = dsc_rdata[0];
                            state_d.st       = S_CHECK;
                        end
                    endcase
                    state_d.idx = state_q.idx + 2'd1;
                end
            end

            S_CHECK: begin
                if (state_q.remain == '0) begin
                    if (state_q.last) begin
                        state_d.st = S_DONE;
                    end else begin
                        state_d.st  = S_FETCH;
                        state_d.ptr = state_q.next_ptr;
                        state_d.idx = 2'd0;
                    end
                end else if (over_budget) begin
                    state_d.st = S_ERR;
                end else begin
                    state_d.st = S_ISSUE;
                end
            end

            S_ISSUE: begin
                if (cmd_ready) state_d.st = S_WAIT;
            end

            S_WAIT: begin
                if (cmd_done) begin
                    state_d.host   = state_q.host + piece_w;
                    state_d.loc    = state_q.loc + piece_w;
                    state_d.remain = state_q.remain - piece_w;
                    state_d.total  = state_q.total + piece_w;
                    if (state_q.remain != piece_w) begin
                        state_d.st = S_ISSUE;
                    end else if (state_q.last) begin
                        state_d.st = S_DONE;
                    end else begin
                        state_d.st  = S_FETCH;
                        state_d.ptr = state_q.next_ptr;
                        state_d.idx = 2'd0;
                    end
                end
            end

            default: state_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dsc_req        = (state_q.st == S_FETCH);
    assign dsc_addr       = state_q.ptr + DW'({state_q.idx, 2'b00});
    assign cmd_valid      = (state_q.st == S_ISSUE);
    assign cmd_host_addr  = state_q.host;
    assign cmd_local_addr = state_q.loc;
    assign cmd_len        = piece_len;
    assign irq            = (state_q.st == S_DONE);

    always_comb begin
        case (reg_addr)
            REG_BASE: reg_rdata = state_q.base;
            REG_STAT: reg_rdata = DW'(status_code(state_q.st));
            REG_BYTES: reg_rdata = bytes_moved;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
    parameter int          DW              = 32,
    parameter int          MAX_PIECE       = 256,
    parameter int          BOUNDARY        = 4096,
    parameter int unsigned MAX_TOTAL_BYTES = 32'd16777216,
    localparam int         LEN_W           = $clog2(MAX_PIECE) + 1,
    localparam int         BW              = $clog2(BOUNDARY)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dsc_req,
    input logic [1:0]       dsc_addr_lo,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [DW-1:0]    cmd_host_addr,
    input logic [DW-1:0]    cmd_local_addr,
    input logic [LEN_W-1:0] cmd_len,
    input logic             irq,
    input logic [DW-1:0]    total
);
    p_dsc_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req |-> dsc_addr_lo == 2'b00);

    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0) && (cmd_len <= LEN_W'(MAX_PIECE)));

    p_no_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_host_addr[BW-1:0]} + (BW+1)'(cmd_len)) <= (BW+1)'(BOUNDARY));

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !start) |=> irq);

    p_budget_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        total <= DW'(MAX_TOTAL_BYTES));

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_host_addr)
            && $stable(cmd_local_addr) && $stable(cmd_len));

    p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && dsc_req));
endmodule

bind sgw_walker sgw_walker_chk #(
    .DW(DW), .MAX_PIECE(MAX_PIECE), .BOUNDARY(BOUNDARY), .MAX_TOTAL_BYTES(MAX_TOTAL_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .dsc_req       (dsc_req),
    .dsc_addr_lo   (dsc_addr[1:0]),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_host_addr (cmd_host_addr),
    .cmd_local_addr(cmd_local_addr),
    .cmd_len       (cmd_len),
    .irq           (irq),
    .total         (bytes_moved)
);

// File: tb/sgw_walker_bench.sv
module sgw_walker_bench;
    localparam int unsigned LIMIT = 20000;

    logic        clk, rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        dsc_req, dsc_ack;
    logic [31:0] dsc_addr, dsc_rdata;
    logic        cmd_valid, cmd_ready, cmd_done, irq;
    logic [31:0] cmd_host_addr, cmd_local_addr;
    logic [8:0]  cmd_len;

    sgw_walker #(.MAX_TOTAL_BYTES(LIMIT)) u_sgw_walker (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_host_addr(cmd_host_addr),
        .cmd_local_addr(cmd_local_addr), .cmd_len(cmd_len), .cmd_done(cmd_done), .irq(irq)
    );

    int nchk = 0, nfail = 0;
    logic [31:0] mem [0:255];
    int          exp_n, exp_status, obs_n;
    longint      exp_total;
    logic [31:0] eh [0:511];
    logic [31:0] el [0:511];
    int          elen [0:511];

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    // Descriptor memory responder.
    initial begin
        int dly = 0;
        dsc_ack = 0; dsc_rdata = 0;
        forever begin
            @(negedge clk);
            if (dsc_ack) dsc_ack = 0;
            else if (dsc_req) begin
                if (dly == 0) begin
                    dsc_ack = 1;
                    dsc_rdata = mem[dsc_addr[9:2]];
                    dly = int'($urandom % 3);
                end else dly--;
            end
        end
    end

    // Data mover model: checks each accepted piece against the expected list.
    initial begin
        int dly = 0;
        bit pend = 0;
        cmd_ready = 0; cmd_done = 0;
        forever begin
            @(negedge clk);
            cmd_done = 0;
            if (pend) begin
                if (dly == 0) begin cmd_done = 1; pend = 0; end
                else dly--;
            end
            cmd_ready = ($urandom % 4) != 0;
            if (cmd_valid && cmd_ready && !pend) begin
                if (obs_n < exp_n) begin
                    check(cmd_host_addr == eh[obs_n], "R4", "piece host addr", cmd_host_addr, eh[obs_n]);
                    check(cmd_local_addr == el[obs_n], "R4", "piece local addr", cmd_local_addr, el[obs_n]);
                    check(int'(cmd_len) == elen[obs_n], "R3", "piece length", cmd_len, elen[obs_n]);
                end else begin
                    check(0, "R7", "unexpected extra piece", obs_n, exp_n);
                end
                obs_n++;
                pend = 1;
                dly = int'($urandom % 3);
            end
        end
    end

    // Reference walk of the descriptor chain.
    task automatic build_expect(input logic [31:0] base);
        logic [31:0] ptr, h, l, cnt, link, r;
        int p, room;
        ptr = base; exp_n = 0; exp_total = 0; exp_status = 3;
        for (int g = 0; g < 16; g++) begin
            cnt  = mem[ptr[9:2]];
            h    = mem[ptr[9:2] + 8'd1];
            l    = mem[ptr[9:2] + 8'd2];
            link = mem[ptr[9:2] + 8'd3];
            if (cnt != 0) begin
                if (exp_total + longint'(cnt) > longint'(LIMIT)) begin
                    exp_status = 4;
                    break;
                end
                r = cnt;
                while (r != 0) begin
                    room = 4096 - int'(h[11:0]);
                    p = 256;
                    if (room < p) p = room;
                    if (r < 32'(p)) p = int'(r);
                    eh[exp_n] = h; el[exp_n] = l; elen[exp_n] = p; exp_n++;
                    h = h + 32'(p); l = l + 32'(p); r = r - 32'(p);
                    exp_total += p;
                end
            end
            if (link[0]) break;
            ptr = {link[31:2], 2'b00};
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 0; reg_addr = 2'd2;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] cnt, input logic [31:0] h,
                            input logic [31:0] l, input int nxt, input bit last);
        mem[slot*4]     = cnt;
        mem[slot*4 + 1] = h;
        mem[slot*4 + 2] = l;
        mem[slot*4 + 3] = 32'(nxt * 16) | {31'b0, last};
    endtask

    task automatic run_list(input int slot, input bit busy_go, input string tag);
        logic [31:0] v;
        bit saw_fetch = 0, saw_xfer = 0, poked = 0;
        int cyc = 0;
        build_expect(32'(slot * 16));
        obs_n = 0;
        wr(2'd0, 32'(slot * 16));
        rd(2'd0, v);
        check(v == 32'(slot * 16), "R9", "base readback", v, slot * 16);
        wr(2'd1, 32'd1);
        check(irq == 1'b0, "R5", "irq cleared by start", irq, 0);
        forever begin
            @(negedge clk);
            cyc++;
            rd(2'd2, v);
            if (v == 1) saw_fetch = 1;
            if (v == 2) saw_xfer = 1;
            if (v == 3 || v == 4 || cyc > 20000) break;
            if (busy_go && saw_xfer && !poked) begin
                poked = 1;
                wr(2'd0, 32'h3F0);
                wr(2'd1, 32'd1); // R10: start while busy
            end
        end
        repeat (6) @(negedge clk);
        rd(2'd2, v);
        check(v == 32'(exp_status), exp_status == 4 ? "R6" : "R5", {tag, " final status"}, v, exp_status);
        check(irq == (exp_status == 3), "R5", {tag, " irq level"}, irq, exp_status == 3);
        check(obs_n == exp_n, exp_n == 0 ? "R7" : "R11", {tag, " piece count"}, obs_n, exp_n);
        rd(2'd3, v);
        check(longint'(v) == exp_total, busy_go ? "R10" : "R8", {tag, " bytes moved"}, v, exp_total);
        if (exp_n > 0) begin
            check(saw_fetch, "R9", {tag, " fetch status seen"}, saw_fetch, 1);
            check(saw_xfer, "R9", {tag, " transfer status seen"}, saw_xfer, 1);
        end
        check(!dsc_req && !cmd_valid, "R2", {tag, " channels quiet at end"}, dsc_req | cmd_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem[i] = 0;
        obs_n = 0; exp_n = 0;
        rst_n = 0; reg_we = 0; reg_addr = 2'd2; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(2'd2, v);
        check(v == 0, "R1", "reset status", v, 0);
        rd(2'd3, v);
        check(v == 0, "R1", "reset byte count", v, 0);
        check(!irq && !dsc_req && !cmd_valid, "R1", "reset outputs", {irq, dsc_req, cmd_valid}, 0);

        // R4: segment starting 16 bytes below a boundary, plus a start while busy (R10).
        put_desc(2, 32'd768, 32'h0001_0FF0, 32'h0000_2000, 0, 1);
        run_list(2, 1, "boundary split");

        // R2/R7: chain 5 -> 9 -> 1 with an empty middle entry.
        put_desc(5, 32'd300, 32'h0000_3FFC, 32'h1000_0000, 9, 0);
        put_desc(9, 32'd0, 32'h0, 32'h0, 1, 0);
        put_desc(1, 32'd50, 32'h0000_1234, 32'h2000_0000, 0, 1);
        run_list(5, 0, "linked chain");

        // R7: final descriptor empty, no pieces at all.
        put_desc(12, 32'd0, 32'h5000, 32'h6000, 0, 1);
        run_list(12, 0, "empty list");

        // R4: host address wraps past 2^32.
        put_desc(20, 32'd300, 32'hFFFF_FF80, 32'h7000_0000, 0, 1);
        run_list(20, 0, "address wrap");

        // R6: second segment overshoots the budget.
        put_desc(30, 32'd12000, 32'h0000_0100, 32'h0, 31, 0);
        put_desc(31, 32'd9000, 32'h0008_0000, 32'h0, 0, 1);
        run_list(30, 0, "budget overshoot");

        // R6: run that lands exactly on the budget.
        put_desc(31, 32'd8000, 32'h0008_0000, 32'h0, 0, 1);
        run_list(30, 0, "budget exact");

        // Random chains.
        for (int t = 0; t < 20; t++) begin
            int n = 1 + int'($urandom % 4);
            int s0 = 40 + int'($urandom % 8);
            for (int k = 0; k < n; k++) begin
                int s = 40 + (s0 - 40 + k * 5) % 24;
                int sn = 40 + (s0 - 40 + (k + 1) * 5) % 24;
                logic [31:0] cnt = ($urandom % 5 == 0) ? 32'd0 : 32'($urandom % 1200);
                put_desc(s, cnt, $urandom, $urandom, sn, k == n - 1);
            end
            run_list(s0, 0, "random chain");
        end

        summary();
        $finish;
    end
endmodule